// File: doc/BRIEF.md
# Ineffectual Instruction Removal Predictor

This block decides which dynamic instructions a speculative leading thread may leave out. A trailing thread executes the whole program. Each instruction it retires produces a report, and the block learns from those reports. Stores that are overwritten before any read, stores that write the value already held, and branches whose outcome has been guessed correctly over and over are all classed as ineffectual. When the same program counter has been reported as ineffectual enough times in a row, the predictor tells the leading thread to skip that instruction. Every other instruction runs normally.

The block has a direct-mapped table of 256 entries. Each entry holds a valid bit, a tag and a 3-bit saturating confidence count. A lookup port takes a fetch PC and, one cycle later, returns hit and remove flags. When the trailing thread sees a branch or value mismatch caused by a wrong removal, the recovery input clears the confidence of the offending PC. A flush input drops every entry at once.

Top module: `irp_top`

## Requirements
- R1: While reset is low, and after it is released, every entry is invalid, and `lk_hit` and `lk_remove` are 0 until a report allocates an entry.
- R2: `lk_hit` and `lk_remove` give the decision for the PC presented with `lk_valid` high on the previous clock edge. Both are 0 in the cycle after `lk_valid` was low.
- R3: The entry index is PC bits [9:2] and the tag is PC bits [31:10]. A lookup hits only when the indexed entry is valid and its tag equals the PC's tag, so another PC that maps to the same index misses.
- R4: A report whose PC misses allocates the indexed entry, replacing whatever was there, with confidence 1 if the report is ineffectual and 0 otherwise.
- R5: An ineffectual report that hits raises the confidence by one, and the confidence saturates at 7.
- R6: An effectual report that hits sets the confidence to 0.
- R7: `lk_remove` is 1 only for a hit whose confidence is 7. A PC therefore needs seven ineffectual reports in a row before it is removed.
- R8: The report cause is 0 for a dead write, 1 for a silent write, 2 for a steadily predicted branch and 3 for none. A report counts as ineffectual only when `rp_ineff` is 1 and the cause is not 3.
- R9: A recovery pulse whose PC hits sets that entry's confidence to 0. A recovery pulse whose PC misses changes nothing.
- R10: `flush` invalidates every entry in one cycle and takes priority over recovery and reports in the same cycle, so a report in that cycle is dropped.
- R11: If a recovery clears an index in the same cycle as a report to that index, the clear wins and the report is dropped. A lookup made in the same cycle as any update sees the table as it was before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate every entry |
| lk_valid | input | 1 | Lookup request from the leading thread |
| lk_pc | input | 32 | Fetch PC to look up |
| rp_valid | input | 1 | Retire report from the trailing thread |
| rp_pc | input | 32 | PC of the retired instruction |
| rp_ineff | input | 1 | 1 when the instruction was ineffectual |
| rp_cause | input | 2 | Reason code (0 dead write, 1 silent write, 2 steady branch, 3 none) |
| rc_valid | input | 1 | Removal misprediction detected |
| rc_pc | input | 32 | PC of the mispredicted removal |
| lk_hit | output | 1 | Previous lookup matched a valid entry |
| lk_remove | output | 1 | Previous lookup may be skipped |

## Verification
Several properties are checked on every cycle:
- A remove flag always comes with a hit.
- An idle lookup port produces quiet outputs in the next cycle.
- After a flush, nothing hits.
- Only a report that hits can write the maximum confidence.
- After a recovery, its index cannot signal removal in the following cycle.

The exact counting, which comes from saturation, clearing, cause decoding, tag replacement and the precedence between a flush, a recovery and a report landing on one index, can only be shown by the bench. The bench's behavioural table model runs directed sequences and a long random mix, and it compares the outputs on every clock.

// File: rtl/irp_pkg.sv
package irp_pkg;

  typedef enum logic [1:0] {
    CAUSE_DEAD_WRITE    = 2'd0,
    CAUSE_SILENT_WRITE  = 2'd1,
    CAUSE_STEADY_BRANCH = 2'd2,
    CAUSE_NONE          = 2'd3
  } cause_e;

  // A report counts toward removal only with the flag set and a real cause.
  function automatic logic counts_as_ineff(input logic flag, input logic [1:0] cause);
    return flag && (cause != CAUSE_NONE);
  endfunction

endpackage

// File: rtl/irp_update.sv
module irp_update #(
  parameter int TAG_W  = 22,
  parameter int CONF_W = 3
) (
  input  logic              cur_valid,
  input  logic [TAG_W-1:0]  cur_tag,
  input  logic [CONF_W-1:0] cur_conf,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic              ineff,
  output logic              hit,
  output logic [CONF_W-1:0] nxt_conf
);
  localparam logic [CONF_W-1:0] CONF_MAX = {CONF_W{1'b1}};

  function automatic logic [CONF_W-1:0] conf_step(
    input logic was_hit, input logic [CONF_W-1:0] conf, input logic is_ineff);
    if (!was_hit)           return is_ineff ? CONF_W'(1) : '0;
    else if (!is_ineff)     return '0;
    else if (conf == CONF_MAX) return CONF_MAX;
    else                    return conf + CONF_W'(1);
  endfunction

  assign hit      = cur_valid && (cur_tag == req_tag);
  assign nxt_conf = conf_step(hit, cur_conf, ineff);
endmodule

// File: rtl/irp_table.sv
module irp_table #(
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 22,
  parameter int CONF_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [CONF_W-1:0] wr_conf,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic              ra_valid,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [CONF_W-1:0] ra_conf,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic              rb_valid,
  output logic [TAG_W-1:0]  rb_tag,
  output logic [CONF_W-1:0] rb_conf,
  input  logic [IDX_W-1:0]  rc_idx,
  output logic              rc_valid,
  output logic [TAG_W-1:0]  rc_tag
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  v_all;
  logic [TAG_W-1:0]  t_all [DEPTH];
  logic [CONF_W-1:0] c_all [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic              v_q;
    logic [TAG_W-1:0]  t_q;
    logic [CONF_W-1:0] c_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
        c_q <= '0;
      end else if (flush) begin
        v_q <= 1'b0;
      end else if (clr_en && clr_idx == IDX_W'(e)) begin
        c_q <= '0;
      end else if (wr_en && wr_idx == IDX_W'(e)) begin
        v_q <= 1'b1;
        t_q <= wr_tag;
        c_q <= wr_conf;
      end
    end
    assign v_all[e] = v_q;
    assign t_all[e] = t_q;
    assign c_all[e] = c_q;
  end

  assign ra_valid = v_all[ra_idx];
  assign ra_tag   = t_all[ra_idx];
  assign ra_conf  = c_all[ra_idx];
  assign rb_valid = v_all[rb_idx];
  assign rb_tag   = t_all[rb_idx];
  assign rb_conf  = c_all[rb_idx];
  assign rc_valid = v_all[rc_idx];
  assign rc_tag   = t_all[rc_idx];
endmodule

// File: rtl/irp_top.sv
module irp_top #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 8,
  parameter int OFS_W  = 2,
  parameter int CONF_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            rp_valid,
  input  logic [PC_W-1:0] rp_pc,
  input  logic            rp_ineff,
  input  logic [1:0]      rp_cause,
  input  logic            rc_valid,
  input  logic [PC_W-1:0] rc_pc,
  output logic            lk_hit,
  output logic            lk_remove
);
  import irp_pkg::*;

  localparam int TAG_W = PC_W - IDX_W - OFS_W;
  localparam logic [CONF_W-1:0] CONF_MAX = {CONF_W{1'b1}};

  function automatic logic [IDX_W-1:0] idx_of(input logic [PC_W-1:0] pc);
    return pc[OFS_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [PC_W-1:0] pc);
    return pc[OFS_W+IDX_W +: TAG_W];
  endfunction

  logic [IDX_W-1:0]  lk_idx, rp_idx, rc_idx;
  logic [TAG_W-1:0]  lk_tag, rp_tag, rc_tag;
  logic              la_valid, rb_valid, rcv_valid;
  logic [TAG_W-1:0]  la_tag, rb_tag, rcv_tag;
  logic [CONF_W-1:0] la_conf, rb_conf;

  assign lk_idx = idx_of(lk_pc);
  assign rp_idx = idx_of(rp_pc);
  assign rc_idx = idx_of(rc_pc);
  assign lk_tag = tag_of(lk_pc);
  assign rp_tag = tag_of(rp_pc);
  assign rc_tag = tag_of(rc_pc);

  // Named internal events, brought out for the checker.
  logic lk_hit_now, lk_rem_now;
  logic rp_is_ineff, upd_hit, rp_hit_now;
  logic rc_fire, rp_block, wr_en;
  logic [CONF_W-1:0] wr_conf;

  assign lk_hit_now  = lk_valid && la_valid && (la_tag == lk_tag);
  assign lk_rem_now  = lk_hit_now && (la_conf == CONF_MAX);
  assign rp_is_ineff = counts_as_ineff(rp_ineff, rp_cause);
  assign rp_hit_now  = rp_valid && upd_hit;
  assign rc_fire     = rc_valid && !flush && rcv_valid && (rcv_tag == rc_tag);
  assign rp_block    = rc_fire && (rc_idx == rp_idx);
  assign wr_en       = rp_valid && !flush && !rp_block;

  irp_update #(.TAG_W(TAG_W), .CONF_W(CONF_W)) u_upd (
    .cur_valid (rb_valid),
    .cur_tag   (rb_tag),
    .cur_conf  (rb_conf),
    .req_tag   (rp_tag),
    .ineff     (rp_is_ineff),
    .hit       (upd_hit),
    .nxt_conf  (wr_conf)
  );

  irp_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .CONF_W(CONF_W)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .clr_en   (rc_fire),
    .clr_idx  (rc_idx),
    .wr_en    (wr_en),
    .wr_idx   (rp_idx),
    .wr_tag   (rp_tag),
    .wr_conf  (wr_conf),
    .ra_idx   (lk_idx),
    .ra_valid (la_valid),
    .ra_tag   (la_tag),
    .ra_conf  (la_conf),
    .rb_idx   (rp_idx),
    .rb_valid (rb_valid),
    .rb_tag   (rb_tag),
    .rb_conf  (rb_conf),
    .rc_idx   (rc_idx),
    .rc_valid (rcv_valid),
    .rc_tag   (rcv_tag)
  );

  // Decision register: reads the pre-update table (R11).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_hit    <= 1'b0;
      lk_remove <= 1'b0;
    end else begin
      lk_hit    <= lk_hit_now;
      lk_remove <= lk_rem_now;
    end
  end

  logic unused_pc_bits;
  assign unused_pc_bits = ^{lk_pc[OFS_W-1:0], rp_pc[OFS_W-1:0], rc_pc[OFS_W-1:0]};
endmodule

// File: rtl/irp_checker.sv
module irp_checker #(
  parameter int IDX_W  = 8,
  parameter int CONF_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              lk_valid,
  input logic              lk_hit,
  input logic              lk_remove,
  input logic              lk_hit_now,
  input logic              lk_rem_now,
  input logic              rp_hit_now,
  input logic              wr_en,
  input logic [CONF_W-1:0] wr_conf,
  input logic              rc_fire,
  input logic [IDX_W-1:0]  rc_idx,
  input logic [IDX_W-1:0]  lk_idx
);
  localparam logic [CONF_W-1:0] CONF_MAX = {CONF_W{1'b1}};

  a_r7_remove_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_remove |-> lk_hit);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!lk_hit && !lk_remove));

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!lk_hit_now && !rp_hit_now));

  a_r4_max_only_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_conf == CONF_MAX) |-> rp_hit_now);

  a_r9_recover_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rc_fire |=> !(lk_rem_now && lk_idx == $past(rc_idx)));
endmodule

bind irp_top irp_checker #(.IDX_W(IDX_W), .CONF_W(CONF_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .lk_valid   (lk_valid),
  .lk_hit     (lk_hit),
  .lk_remove  (lk_remove),
  .lk_hit_now (lk_hit_now),
  .lk_rem_now (lk_rem_now),
  .rp_hit_now (rp_hit_now),
  .wr_en      (wr_en),
  .wr_conf    (wr_conf),
  .rc_fire    (rc_fire),
  .rc_idx     (rc_idx),
  .lk_idx     (lk_idx)
);

// File: tb/tb_irp_top.sv
module tb_irp_top;
  localparam int CLK_PERIOD = 10;
  localparam int NENT = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        rp_valid = 1'b0;
  logic [31:0] rp_pc = '0;
  logic        rp_ineff = 1'b0;
  logic [1:0]  rp_cause = '0;
  logic        rc_valid = 1'b0;
  logic [31:0] rc_pc = '0;
  logic        lk_hit, lk_remove;

  always #(CLK_PERIOD/2) clk = ~clk;

  irp_top dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_pc(lk_pc),
    .rp_valid(rp_valid), .rp_pc(rp_pc), .rp_ineff(rp_ineff), .rp_cause(rp_cause),
    .rc_valid(rc_valid), .rc_pc(rc_pc),
    .lk_hit(lk_hit), .lk_remove(lk_remove)
  );

  int nvec = 0;
  int nfail = 0;
  bit done = 0;

  // Behavioural model of the table.
  int m_valid [NENT];
  int m_tag   [NENT];
  int m_conf  [NENT];

  function automatic int ix(input logic [31:0] pc);
    return int'((pc >> 2) & 32'hFF);
  endfunction
  function automatic int tg(input logic [31:0] pc);
    return int'(pc >> 10);
  endfunction

  // Next stimulus, applied by tick().
  logic        s_flush, s_lk, s_rp, s_ineff, s_rc;
  logic [31:0] s_lk_pc, s_rp_pc, s_rc_pc;
  logic [1:0]  s_cause;

  task automatic idle_stim();
    s_flush = 0; s_lk = 0; s_rp = 0; s_ineff = 0; s_rc = 0;
    s_lk_pc = '0; s_rp_pc = '0; s_rc_pc = '0; s_cause = 2'd0;
  endtask

  task automatic check(input string req, input logic act, input logic exp, input string what);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Called at a falling edge: drive, predict, advance model, compare next falling edge.
  task automatic tick(input string req);
    logic eh, er;
    int   ri, ci;
    bit   rc_hit, blocked, hit, inef;
    flush = s_flush; lk_valid = s_lk; lk_pc = s_lk_pc;
    rp_valid = s_rp; rp_pc = s_rp_pc; rp_ineff = s_ineff; rp_cause = s_cause;
    rc_valid = s_rc; rc_pc = s_rc_pc;
    eh = s_lk && m_valid[ix(s_lk_pc)] != 0 && m_tag[ix(s_lk_pc)] == tg(s_lk_pc);
    er = eh && m_conf[ix(s_lk_pc)] == 7;
    if (s_flush) begin
      for (int k = 0; k < NENT; k++) m_valid[k] = 0;
    end else begin
      ci = ix(s_rc_pc);
      rc_hit = s_rc && m_valid[ci] != 0 && m_tag[ci] == tg(s_rc_pc);
      if (rc_hit) m_conf[ci] = 0;
      ri = ix(s_rp_pc);
      blocked = rc_hit && ci == ri;
      if (s_rp && !blocked) begin
        inef = s_ineff && s_cause != 2'd3;
        hit = m_valid[ri] != 0 && m_tag[ri] == tg(s_rp_pc);
        if (!hit) begin
          m_valid[ri] = 1; m_tag[ri] = tg(s_rp_pc); m_conf[ri] = inef ? 1 : 0;
        end else if (!inef) m_conf[ri] = 0;
        else if (m_conf[ri] < 7) m_conf[ri] = m_conf[ri] + 1;
      end
    end
    @(negedge clk);
    check(req, lk_hit, eh, "lk_hit");
    check(req, lk_remove, er, "lk_remove");
    idle_stim();
  endtask

  task automatic do_look(input logic [31:0] pc, input string req);
    s_lk = 1; s_lk_pc = pc; tick(req);
  endtask

  task automatic do_rep(input logic [31:0] pc, input logic inef, input logic [1:0] cause,
                        input bit also_look, input string req);
    s_rp = 1; s_rp_pc = pc; s_ineff = inef; s_cause = cause;
    s_lk = also_look; s_lk_pc = pc;
    tick(req);
  endtask

  localparam logic [31:0] PA = 32'h0000_1040;  // index 0x10
  localparam logic [31:0] PB = 32'h0000_2040;  // index 0x10, other tag
  localparam logic [31:0] PC = 32'h0000_0100;  // index 0x40
  localparam logic [31:0] PD = 32'h0000_3104;  // index 0x41

  initial begin
    for (int k = 0; k < NENT; k++) begin m_valid[k] = 0; m_tag[k] = 0; m_conf[k] = 0; end
    idle_stim();
    repeat (3) @(negedge clk);
    check("R1", lk_hit, 1'b0, "lk_hit in reset");
    check("R1", lk_remove, 1'b0, "lk_remove in reset");
    rst_n = 1'b1;
    @(negedge clk);
    do_look(PA, "R1");
    // Seven ineffectual reports, each with a same-cycle lookup (R11, R7, R5).
    for (int k = 0; k < 7; k++) do_rep(PA, 1'b1, 2'(k % 3), 1'b1, "R7");
    do_look(PA, "R7");
    do_rep(PA, 1'b1, 2'd0, 1'b0, "R5");
    do_look(PA, "R5");
    do_look(PB, "R3");
    do_look(PD, "R3");
    s_lk = 0; tick("R2");
    do_rep(PA, 1'b0, 2'd0, 1'b0, "R6");
    do_look(PA, "R6");
    // Cause NONE with flag set counts as effectual (R8).
    for (int k = 0; k < 7; k++) do_rep(PC, 1'b1, 2'd2, 1'b0, "R8");
    do_look(PC, "R8");
    do_rep(PC, 1'b1, 2'd3, 1'b0, "R8");
    do_look(PC, "R8");
    // Recovery: miss has no effect, hit clears (R9).
    for (int k = 0; k < 7; k++) do_rep(PC, 1'b1, 2'd1, 1'b0, "R9");
    s_rc = 1; s_rc_pc = PC + 32'h400; tick("R9");
    do_look(PC, "R9");
    s_rc = 1; s_rc_pc = PC; s_lk = 1; s_lk_pc = PC; tick("R9");
    do_look(PC, "R9");
    // Recovery and report on one index in one cycle (R11).
    for (int k = 0; k < 7; k++) do_rep(PD, 1'b1, 2'd0, 1'b0, "R11");
    s_rc = 1; s_rc_pc = PD; s_rp = 1; s_rp_pc = PD; s_ineff = 1; tick("R11");
    do_look(PD, "R11");
    // Replacement on tag miss (R4).
    do_rep(PB, 1'b1, 2'd0, 1'b0, "R4");
    do_look(PA, "R4");
    do_look(PB, "R4");
    do_rep(PA, 1'b0, 2'd1, 1'b0, "R4");
    do_look(PA, "R4");
    // Flush with a report in the same cycle (R10).
    s_flush = 1; s_rp = 1; s_rp_pc = PD; s_ineff = 1; s_lk = 1; s_lk_pc = PD; tick("R10");
    do_look(PD, "R10");
    do_look(PA, "R10");
    // Random mix compared every clock.
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] pool [4];
      pool[0] = PA; pool[1] = PB; pool[2] = PC; pool[3] = PD;
      s_lk = ($urandom % 4) != 0;  s_lk_pc = pool[$urandom % 4];
      s_rp = ($urandom % 3) != 0;  s_rp_pc = pool[$urandom % 4];
      s_ineff = ($urandom % 8) != 0; s_cause = 2'($urandom % 4);
      s_rc = ($urandom % 16) == 0; s_rc_pc = pool[$urandom % 4];
      s_flush = ($urandom % 200) == 0;
      tick("R2");
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule